// File: doc/BRIEF.md
# Triggered Sample Acquisition Controller

This block decides which samples from an upstream filter are kept. Each sample arrives with a one-cycle valid strobe. A small control word selects the acquisition mode, the trigger input and its edge, how many leading samples to skip, and the FIFO threshold. Depending on the mode, acquisition begins as soon as the enable is set, or waits for an edge on one of two trigger lines. It then either keeps storing until the enable drops, or stops after a single stored sample.

Kept samples go into an eight-entry, 24-bit receive FIFO. A consumer drains the FIFO through a first-word-fall-through read port. A threshold event tells the consumer when data is ready, and a DMA request is that event gated by a DMA enable. Two status flags are provided. The run flag shows that samples are being accepted. The active flag shows that the unit has not yet returned to its idle state.

Top module: `sacq_ctrl`

## Requirements
- R1: When `en` is 0, no sample is stored in that same cycle, and `run` and `active` read 0 from the next cycle on.
- R2: Mode codes 0, 1, 4 and 5 are immediate. `run` and `active` read 1 one cycle after `en` is set. Mode 5 acts like mode 0.
- R3: Mode codes 2 and 3 are trigger-started. After `en` is set, `active` reads 1 and `run` reads 0. `run` becomes 1 in the cycle after the selected trigger event.
- R4: With `trig_fall` = 0, a rising edge of the selected trigger is the event. With `trig_fall` = 1, a falling edge is the event.
- R5: `trig_src` = 0 selects `trig_a` and `trig_src` = 2 selects `trig_b`. Codes 1 and 3 select a constant-low line, so no event ever occurs and the window stays closed.
- R6: Each time the block enters the accepting state, the first `skip_n` valid samples are dropped. Storing begins with the next valid sample.
- R7: With `thr_half` = 0, `thr_evt` is 1 whenever the FIFO holds at least one entry. With `thr_half` = 1, it is 1 when the FIFO holds at least 4 entries. `dma_req` equals `thr_evt` AND `dma_en`.
- R8: Single-shot modes stop accepting after one stored sample. Mode 1 then holds with `run` = 0 and `active` = 1 until `en` clears. Mode 3 returns to waiting for a trigger, and the next event starts acquisition again.
- R9: Mode 4 stores only while the selected trigger line is high. Samples outside that window are neither stored nor counted as discards.
- R10: Mode codes 6 and 7 keep the unit idle. Nothing is stored, and `run` and `active` stay 0.
- R11: The FIFO holds 8 entries of 24 bits and returns them in arrival order. A write while it is full is dropped and sets the sticky `ovf` flag, which only reset clears.
- R12: After reset, `run`, `active`, `thr_evt`, `dma_req` and `ovf` are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Acquisition enable |
| mode | input | 3 | Acquisition mode code |
| trig_fall | input | 1 | Trigger edge: 0 rising, 1 falling |
| trig_src | input | 2 | Trigger line select |
| skip_n | input | 4 | Leading samples to discard |
| thr_half | input | 1 | Threshold select: 0 not empty, 1 half full |
| dma_en | input | 1 | Gates the DMA request |
| trig_a | input | 1 | First trigger candidate |
| trig_b | input | 1 | Second trigger candidate |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 24 | Sample value |
| rd_en | input | 1 | Pop one FIFO entry |
| rd_data | output | 24 | FIFO head entry |
| fifo_count | output | 4 | Entries held |
| fifo_empty | output | 1 | FIFO holds nothing |
| thr_evt | output | 1 | Threshold event |
| dma_req | output | 1 | DMA request |
| run | output | 1 | Samples are being accepted |
| active | output | 1 | Unit not yet back to idle |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a sample strobe that lands in the very cycle the enable falls, while the state machine is still registered as running. The bench drives the enable low and the valid strobe high on the same falling clock edge. It then checks that the FIFO stays empty.

Single-shot re-arming is also awkward to reach. The trigger must first return to its idle level before a second edge can exist, so the bench lowers and raises the trigger around the stored sample. In window mode, the bench alternates the trigger level between samples. This shows that samples outside the window do not use up the discard count.

// File: rtl/sacq_pkg.sv
package sacq_pkg;

    localparam int SMP_W      = 24;
    localparam int FIFO_DEPTH = 8;
    localparam int SKIP_W     = 4;

    typedef enum logic [2:0] {
        MD_ASYNC_CONT = 3'd0,
        MD_ASYNC_ONE  = 3'd1,
        MD_SYNC_CONT  = 3'd2,
        MD_SYNC_ONE   = 3'd3,
        MD_WINDOW     = 3'd4,
        MD_ASYNC_ALT  = 3'd5,
        MD_RSV6       = 3'd6,
        MD_RSV7       = 3'd7
    } acq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_HOLD  = 2'd3
    } acq_state_e;

    typedef struct packed {
        logic level;
        logic event_hit;
    } trig_info_t;

    function automatic logic mode_ok(input logic [2:0] m);
        return m <= 3'd5;
    endfunction

    function automatic logic mode_triggered(input logic [2:0] m);
        return (m == MD_SYNC_CONT) || (m == MD_SYNC_ONE);
    endfunction

    function automatic logic mode_single(input logic [2:0] m);
        return (m == MD_ASYNC_ONE) || (m == MD_SYNC_ONE);
    endfunction

endpackage

// File: rtl/sacq_trig_sel.sv
module sacq_trig_sel
    import sacq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_a,
    input  logic       trig_b,
    input  logic [1:0] src,
    input  logic       fall,
    output trig_info_t info
);

    logic sel;
    logic prev;

    always_comb begin
        case (src)
            2'd0:    sel = trig_a;
            2'd2:    sel = trig_b;
            default: sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sel;
    end

    always_comb begin
        info.level     = sel;
        info.event_hit = fall ? (prev & ~sel) : (sel & ~prev);
    end

endmodule

// File: rtl/sacq_fsm.sv
module sacq_fsm
    import sacq_pkg::*;
#(
    parameter int SKW = SKIP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [2:0]     mode,
    input  logic [SKW-1:0] skip_n,
    input  trig_info_t     trig,
    input  logic           smp_valid,
    output logic           store,
    output logic           run_o,
    output logic           active_o
);

    acq_state_e     state, state_nx;
    logic [SKW-1:0] skip_cnt;
    logic           gate, take, enter_run, live;

    assign live = en && mode_ok(mode);

    always_comb begin
        gate  = (mode == MD_WINDOW) ? trig.level : 1'b1;
        take  = live && (state == ST_RUN) && smp_valid && gate;
        store = take && (skip_cnt == '0);
    end

    always_comb begin
        state_nx = state;
        if (!live) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  state_nx = mode_triggered(mode) ? ST_ARMED : ST_RUN;
                ST_ARMED: if (trig.event_hit) state_nx = ST_RUN;
                ST_RUN:   if (store && mode_single(mode))
                              state_nx = (mode == MD_SYNC_ONE) ? ST_ARMED : ST_HOLD;
                default:  state_nx = state;
            endcase
        end
    end

    assign enter_run = (state != ST_RUN) && (state_nx == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            skip_cnt <= '0;
        end else begin
            state <= state_nx;
            if (enter_run)
                skip_cnt <= skip_n;
            else if (take && skip_cnt != '0)
                skip_cnt <= skip_cnt - 1'b1;
        end
    end

    assign run_o    = (state == ST_RUN);
    assign active_o = (state != ST_IDLE);

    // R1
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE));

    // R3
    trig_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && live && trig.event_hit) |=> run_o);

    // R8
    single_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (store && mode == MD_ASYNC_ONE) |=> !run_o);

    // R10
    rsv_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode > 3'd5) |=> !active_o);

endmodule

// File: rtl/sacq_fifo.sv
module sacq_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       ovf
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, push, pop;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_en && !full;
    assign pop   = rd_en && !empty;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(i))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) ovf <= 1'b1;
        end
    end

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> $stable(count));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/sacq_ctrl.sv
module sacq_ctrl
    import sacq_pkg::*;
#(
    parameter int DW    = SMP_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int SKW   = SKIP_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [2:0]     mode,
    input  logic           trig_fall,
    input  logic [1:0]     trig_src,
    input  logic [SKW-1:0] skip_n,
    input  logic           thr_half,
    input  logic           dma_en,
    input  logic           trig_a,
    input  logic           trig_b,
    input  logic           smp_valid,
    input  logic [DW-1:0]  smp_data,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_data,
    output logic [CW-1:0]  fifo_count,
    output logic           fifo_empty,
    output logic           thr_evt,
    output logic           dma_req,
    output logic           run,
    output logic           active,
    output logic           ovf
);

    trig_info_t trig;
    logic       store;

    sacq_trig_sel u_trig (
        .clk    (clk),
        .rst    (rst),
        .trig_a (trig_a),
        .trig_b (trig_b),
        .src    (trig_src),
        .fall   (trig_fall),
        .info   (trig)
    );

    sacq_fsm #(.SKW(SKW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode),
        .skip_n    (skip_n),
        .trig      (trig),
        .smp_valid (smp_valid),
        .store     (store),
        .run_o     (run),
        .active_o  (active)
    );

    sacq_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store),
        .wr_data (smp_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (fifo_count),
        .empty   (fifo_empty),
        .ovf     (ovf)
    );

    always_comb begin
        thr_evt = thr_half ? (fifo_count >= CW'(DEPTH / 2)) : !fifo_empty;
        dma_req = thr_evt && dma_en;
    end

    // R1
    no_store_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !rd_en) |=> $stable(fifo_count));

    // R7
    dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (thr_evt && !fifo_empty));

endmodule

// File: tb/sacq_ctrl_tb.sv
`timescale 1ns/1ps
module sacq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 0, trig_fall = 0, thr_half = 0, dma_en = 0;
    logic [2:0]  mode = 0;
    logic [1:0]  trig_src = 0;
    logic [3:0]  skip_n = 0;
    logic        trig_a = 0, trig_b = 0, smp_valid = 0, rd_en = 0;
    logic [23:0] smp_data = 0;
    logic [23:0] rd_data;
    logic [3:0]  fifo_count;
    logic        fifo_empty, thr_evt, dma_req, run, active, ovf;

    int n_tests = 0;
    int n_fail  = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    sacq_ctrl u_dut (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .trig_fall(trig_fall),
        .trig_src(trig_src), .skip_n(skip_n), .thr_half(thr_half),
        .dma_en(dma_en), .trig_a(trig_a), .trig_b(trig_b),
        .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
        .rd_data(rd_data), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
        .thr_evt(thr_evt), .dma_req(dma_req), .run(run), .active(active),
        .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: one sample strobe, expected value queued when it should be kept
    task automatic send(input logic [23:0] d, input bit keep);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
        if (keep) exp_q.push_back(d);
    endtask

    // monitor: pops the FIFO and compares against the scoreboard
    task automatic drain(input string tag);
        while (!fifo_empty) begin
            if (exp_q.size() == 0) begin
                chk(0, tag, int'(rd_data), -1);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, tag, int'(rd_data), int'(e));
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(exp_q.size() == 0, tag, 0, exp_q.size());
        exp_q.delete();
    endtask

    task automatic start(input logic [2:0] m, input logic [1:0] s,
                         input logic f, input logic [3:0] k);
        @(negedge clk);
        mode = m; trig_src = s; trig_fall = f; skip_n = k; en = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk);
        en = 1'b0; trig_a = 1'b0; trig_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk(!run && !active, "R12", int'({run, active}), 0);
        chk(fifo_empty && !thr_evt && !dma_req && !ovf, "R12", int'(fifo_count), 0);

        // R2 immediate start, R7 not-empty threshold, R11 order
        dma_en = 1'b1;
        start(3'd0, 2'd0, 1'b0, 4'd0);
        chk(run && active, "R2", int'({run, active}), 3);
        send(24'h000101, 1); send(24'h000202, 1); send(24'hABCDEF, 1);
        chk(thr_evt, "R7", int'(thr_evt), 1);
        chk(dma_req, "R7", int'(dma_req), 1);
        drain("R11");
        chk(!thr_evt, "R7", int'(thr_evt), 0);

        // R1 enable drop on the same cycle as a sample
        @(negedge clk);
        en = 1'b0; smp_valid = 1'b1; smp_data = 24'h0BAD00;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(fifo_empty, "R1", int'(fifo_count), 0);
        chk(!run && !active, "R1", int'({run, active}), 0);

        // R2 mode 5 immediate
        start(3'd5, 2'd0, 1'b0, 4'd0);
        chk(run, "R2", int'(run), 1);
        send(24'h000505, 1);
        drain("R2");
        stop();

        // R6 discard
        start(3'd0, 2'd0, 1'b0, 4'd2);
        send(24'h000011, 0); send(24'h000022, 0);
        send(24'h000033, 1); send(24'h000044, 1);
        drain("R6");
        stop();

        // R3 R5 rising trigger on trig_a
        start(3'd2, 2'd0, 1'b0, 4'd0);
        chk(!run && active, "R3", int'({run, active}), 1);
        send(24'h000EEE, 0);
        @(negedge clk); trig_b = 1'b1;
        @(negedge clk); trig_b = 1'b0;
        @(negedge clk);
        chk(!run, "R5", int'(run), 0);
        trig_a = 1'b1;
        @(negedge clk);
        chk(run, "R3", int'(run), 1);
        send(24'h000777, 1);
        drain("R3");
        stop();

        // R4 R5 falling trigger on trig_b
        start(3'd2, 2'd2, 1'b1, 4'd0);
        trig_b = 1'b1;
        @(negedge clk);
        chk(!run, "R4", int'(run), 0);
        trig_b = 1'b0;
        @(negedge clk);
        chk(run, "R4", int'(run), 1);
        stop();

        // R5 code 1 selects nothing
        start(3'd2, 2'd1, 1'b0, 4'd0);
        trig_a = 1'b1; trig_b = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!run && active, "R5", int'({run, active}), 1);
        stop();

        // R8 async single shot
        start(3'd1, 2'd0, 1'b0, 4'd0);
        send(24'h00AAAA, 1); send(24'h00BBBB, 0);
        chk(!run && active, "R8", int'({run, active}), 1);
        drain("R8");
        stop();

        // R8 sync single shot re-arm
        start(3'd3, 2'd0, 1'b0, 4'd0);
        trig_a = 1'b1;
        @(negedge clk);
        send(24'h00C001, 1);
        chk(!run && active, "R8", int'({run, active}), 1);
        send(24'h00C002, 0);
        trig_a = 1'b0;
        @(negedge clk); trig_a = 1'b1;
        @(negedge clk);
        chk(run, "R8", int'(run), 1);
        send(24'h00C003, 1);
        drain("R8");
        stop();

        // R9 window mode with one discard
        start(3'd4, 2'd0, 1'b0, 4'd1);
        send(24'h000901, 0);
        trig_a = 1'b1;
        send(24'h000902, 0); send(24'h000903, 1);
        trig_a = 1'b0;
        send(24'h000904, 0);
        drain("R9");
        stop();

        // R10 reserved mode
        start(3'd6, 2'd0, 1'b0, 4'd0);
        chk(!run && !active, "R10", int'({run, active}), 0);
        send(24'h000606, 0);
        chk(fifo_empty, "R10", int'(fifo_count), 0);
        stop();

        // R7 half threshold and DMA gating
        thr_half = 1'b1; dma_en = 1'b0;
        start(3'd0, 2'd0, 1'b0, 4'd0);
        for (int i = 0; i < 3; i++) send(24'h007000 + 24'(i), 1);
        chk(!thr_evt, "R7", int'(thr_evt), 0);
        send(24'h007003, 1);
        chk(thr_evt && !dma_req, "R7", int'({thr_evt, dma_req}), 2);
        dma_en = 1'b1;
        #0.5;
        chk(dma_req, "R7", int'(dma_req), 1);

        // R11 overflow
        for (int i = 4; i < 9; i++) send(24'h007000 + 24'(i), i < 8);
        chk(fifo_count == 4'd8, "R11", int'(fifo_count), 8);
        chk(ovf, "R11", int'(ovf), 1);
        drain("R11");
        chk(ovf, "R11", int'(ovf), 1);
        stop();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule